// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches a running BCD calendar (seconds, minutes, hours with a PM indicator, date and weekday) together with a free-running subsecond counter, and compares them against one programmed alarm. Each calendar field of the alarm can be left out of the comparison. The day field is compared either as a date or as a weekday. The subsecond comparison is limited to a programmable number of low-order bits.

Comparisons are taken only on calendar ticks, which are one-cycle enable pulses from the calendar counter. When all fields that take part in the comparison first agree, a sticky alarm flag is set. The flag drives an interrupt line that can be gated off, and an output pin whose active level can be chosen. Software programs the unit through a small word-wide register port. The alarm time word and the subsecond word are write-protected while the alarm is armed, except during initialization mode. A status bit tells software when it is safe to reprogram after disarming. A chip that needs two alarms instantiates the unit twice.

Top module: `cal_alarm_unit`

## Requirements
- R1: With the alarm enabled (control bit 0 at address 0), the flag is set by the calendar tick on which every field that takes part in the comparison is equal. There is no change between ticks, and a disabled alarm never sets the flag.
- R2: Time word (address 1) bits 31, 30, 29 and 28 mask the day, hour, minute and second fields respectively. A masked field is left out of the comparison, and with all four set the calendar is ignored.
- R3: Time word bit 27 selects the meaning of the day field [25:20]. At 0 it is compared with the BCD date. At 1 its low 3 bits are compared with the weekday code.
- R4: Time word bit 26, the alarm PM bit, must equal the PM input only when 12-hour mode is on and the hour field [19:14] is unmasked. In 24-hour mode it is ignored. Minutes are held at [13:7] and seconds at [6:0].
- R5: Subsecond word (address 2) holds the value at [14:0] and a mask code k at [27:24]. Only the low k bits are compared: k=0 compares none and k=15 compares all 15 bits.
- R6: Writes to the time word and to the subsecond word are discarded while the alarm is enabled, unless initialization mode is on. Reads return the held values.
- R7: The writable status (output, and control read bit 5) is low while the alarm is enabled. After a write that disables it, the status rises on the second calendar tick.
- R8: The flag (control read bit 4) stays set until a control write with bit 4 at 0 clears it. A match that continues does not set the flag again after such a clear. A fresh match that follows a mismatch does.
- R9: The interrupt equals the flag when control bit 1 is set and is otherwise low. The pin follows the flag, and is inverted when control bit 2 is set.
- R10: After reset the alarm is disabled, the flag, interrupt and pin are low, writable is high, and the time and subsecond words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_tick | input | 1 | One-cycle pulse per calendar update |
| init_mode | input | 1 | Calendar initialization mode, lifts the write protection |
| hour12 | input | 1 | 12-hour mode select |
| cal_sec | input | 7 | BCD seconds |
| cal_min | input | 7 | BCD minutes |
| cal_hour | input | 6 | BCD hours |
| cal_pm | input | 1 | PM indicator of the calendar |
| cal_date | input | 6 | BCD date of month |
| cal_wday | input | 3 | Weekday code 1 to 7 |
| cal_subsec | input | SS_W | Subsecond counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 time word, 2 subsecond word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| alarm_flag | output | 1 | Sticky alarm flag |
| cfg_writable | output | 1 | Safe-to-reprogram status |
| alarm_irq | output | 1 | Gated interrupt |
| alarm_pin | output | 1 | Alarm pin with selectable polarity |

## Verification
The bench targets the subsecond mask edges: code 0, code 4, code 14, which must ignore bit 14, and code 15, which must see it. A miscounted mask would either miss alarms or fire on the wrong subsecond. It checks the PM bit across both hour modes and with the hour masked, where a careless design fires at the wrong half of the day or never fires. It also checks the weekday selector, where a design that compared the date would fire on the wrong days. It holds a match across a software clear, where a level-triggered flag would come straight back, and it counts ticks to the writable status rise. It also confirms that writes made while armed leave the stored alarm unchanged.

// File: rtl/cal_alarm_pkg.sv
// Shared types and field positions of the calendar alarm unit.
// Assumes a 32-bit register port with three used word addresses.
package cal_alarm_pkg;

    // Alarm time word, most significant field first.
    typedef struct packed {
        logic       day_msk;
        logic       hour_msk;
        logic       min_msk;
        logic       sec_msk;
        logic       wday_sel;
        logic       pm;
        logic [5:0] day;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } alarm_time_t;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_TIME  = 2'd1,
        REG_SUBS  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    localparam int CTL_EN      = 0;
    localparam int CTL_IRQ     = 1;
    localparam int CTL_LOW     = 2;
    localparam int CTL_KEEP    = 4;
    localparam int CTL_WRBL    = 5;
    localparam int SS_CODE_LSB = 24;

endpackage

// File: rtl/cal_alarm_regs.sv
// Register file of one alarm: control bits, protected time and subsecond
// words, flag-clear strobe and the writable status with its tick counter.
// Assumes SS_W <= 24 so the mask code field sits above the value field.
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter  int SS_W       = 15,
    parameter  int SYNC_TICKS = 2,
    localparam int CODE_W     = $clog2(SS_W + 1),
    localparam int CNT_W      = $clog2(SYNC_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_tick,
    input  logic              init_mode,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              alarm_flag,
    output logic [31:0]       rd_data,
    output alarm_time_t       time_cfg,
    output logic [SS_W-1:0]   ss_val,
    output logic [CODE_W-1:0] ss_code,
    output logic              alarm_en,
    output logic              irq_en,
    output logic              pin_low,
    output logic              flag_clr,
    output logic              cfg_writable
);

    logic             wr_ctrl, wr_time, wr_subs, open_q;
    logic [CNT_W-1:0] sync_cnt;

    // Decode the write strobe per register and the protection window.
    always_comb begin
        open_q  = !alarm_en || init_mode;
        wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == REG_CTRL);
        wr_time = wr_en && (reg_addr_e'(wr_addr) == REG_TIME) && open_q;
        wr_subs = wr_en && (reg_addr_e'(wr_addr) == REG_SUBS) && open_q;
        flag_clr = wr_ctrl && !wr_data[CTL_KEEP];
    end

    // Control bits are always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_en <= 1'b0;
            irq_en   <= 1'b0;
            pin_low  <= 1'b0;
        end else if (wr_ctrl) begin
            alarm_en <= wr_data[CTL_EN];
            irq_en   <= wr_data[CTL_IRQ];
            pin_low  <= wr_data[CTL_LOW];
        end
    end

    // Alarm time word, accepted only inside the protection window.
    always_ff @(posedge clk) begin
        if (!rst_n) time_cfg <= '0;
        else if (wr_time) time_cfg <= alarm_time_t'(wr_data);
    end

    // Subsecond value and compare-width code, same protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_val  <= '0;
            ss_code <= '0;
        end else if (wr_subs) begin
            ss_val  <= wr_data[SS_W-1:0];
            ss_code <= wr_data[SS_CODE_LSB +: CODE_W];
        end
    end

    // Tick counter that delays the writable status after a disable.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_cnt <= '0;
        else if (wr_ctrl && alarm_en && !wr_data[CTL_EN]) sync_cnt <= CNT_W'(SYNC_TICKS);
        else if (cal_tick && (sync_cnt != '0)) sync_cnt <= sync_cnt - 1'b1;
    end

    assign cfg_writable = !alarm_en && (sync_cnt == '0);

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            REG_CTRL: begin
                rd_data[CTL_EN]   = alarm_en;
                rd_data[CTL_IRQ]  = irq_en;
                rd_data[CTL_LOW]  = pin_low;
                rd_data[CTL_KEEP] = alarm_flag;
                rd_data[CTL_WRBL] = cfg_writable;
            end
            REG_TIME: rd_data = time_cfg;
            REG_SUBS: begin
                rd_data[SS_W-1:0]                = ss_val;
                rd_data[SS_CODE_LSB +: CODE_W]   = ss_code;
            end
            default: rd_data = '0;
        endcase
    end

    // R6: a protected write while armed leaves the time word unchanged.
    a_r6_time_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd1) && alarm_en && !init_mode) |=> $stable(time_cfg));

    // R6: same for the subsecond word.
    a_r6_subs_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd2) && alarm_en && !init_mode) |=> ($stable(ss_val) && $stable(ss_code)));

    // R7: the status is low right after a disable.
    a_r7_low_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_en) |-> !cfg_writable);

endmodule

// File: rtl/cal_alarm_match.sv
// Combinational comparison of the calendar against the programmed alarm.
// Assumes BCD inputs; no range checking of the values is done.
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter  int SS_W   = 15,
    localparam int CODE_W = $clog2(SS_W + 1)
) (
    input  alarm_time_t       time_cfg,
    input  logic [SS_W-1:0]   ss_val,
    input  logic [CODE_W-1:0] ss_code,
    input  logic              hour12,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic              cal_pm,
    input  logic [5:0]        cal_date,
    input  logic [2:0]        cal_wday,
    input  logic [SS_W-1:0]   cal_subsec,
    output logic              match
);

    logic [SS_W-1:0] ss_keep;
    logic sec_ok, min_ok, hour_ok, day_ok, ss_ok;

    // One compare-enable per subsecond bit: bit i takes part when i < code.
    for (genvar i = 0; i < SS_W; i++) begin : g_keep
        assign ss_keep[i] = (CODE_W'(i) < ss_code);
    end

    // Per-field results, each forced true by its mask.
    always_comb begin
        sec_ok  = time_cfg.sec_msk  || (time_cfg.sec == cal_sec);
        min_ok  = time_cfg.min_msk  || (time_cfg.min == cal_min);
        hour_ok = time_cfg.hour_msk ||
                  ((time_cfg.hour == cal_hour) && (!hour12 || (time_cfg.pm == cal_pm)));
        day_ok  = time_cfg.day_msk  ||
                  (time_cfg.wday_sel ? (time_cfg.day[2:0] == cal_wday)
                                     : (time_cfg.day == cal_date));
        ss_ok   = ((ss_val ^ cal_subsec) & ss_keep) == '0;
        match   = sec_ok && min_ok && hour_ok && day_ok && ss_ok;
    end

    // R2: fully masked calendar with no subsecond bits always matches.
    always_comb begin
        a_r2_all_masked: assert (!(time_cfg.day_msk && time_cfg.hour_msk && time_cfg.min_msk &&
                                   time_cfg.sec_msk && (ss_code == '0)) || match);
    end

endmodule

// File: rtl/cal_alarm_flag.sv
// Sticky alarm flag set on a fresh match at a calendar tick, plus the
// interrupt gate and the polarity-selectable pin.
// Assumes flag_clr is a one-cycle strobe from the register file.
module cal_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_tick,
    input  logic alarm_en,
    input  logic match,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic pin_low,
    output logic alarm_flag,
    output logic alarm_irq,
    output logic alarm_pin
);

    logic seen_q;
    logic set_now;

    assign set_now = cal_tick && alarm_en && match && !seen_q;

    // Remember whether the last tick already matched; forget when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (cal_tick) seen_q <= alarm_en && match;
        else if (!alarm_en) seen_q <= 1'b0;
    end

    // Flag: set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_flag <= 1'b0;
        else if (set_now) alarm_flag <= 1'b1;
        else if (flag_clr) alarm_flag <= 1'b0;
    end

    assign alarm_irq = alarm_flag && irq_en;
    assign alarm_pin = alarm_flag ^ pin_low;

    // R1: the flag only rises at an enabled tick.
    a_r1_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> ($past(cal_tick) && $past(alarm_en)));

    // R8: without a clear the flag holds.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clr) |=> alarm_flag);

    // R8: a continuing match does not raise a cleared flag.
    a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_tick && seen_q && !alarm_flag) |=> !alarm_flag);

endmodule

// File: rtl/cal_alarm_unit.sv
// One calendar alarm: register file, matcher and flag/output stage.
// Assumes the calendar inputs are already in this clock domain and that
// cal_tick pulses for one cycle per calendar update.
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter  int SS_W       = 15,
    parameter  int SYNC_TICKS = 2,
    localparam int CODE_W     = $clog2(SS_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cal_tick,
    input  logic            init_mode,
    input  logic            hour12,
    input  logic [6:0]      cal_sec,
    input  logic [6:0]      cal_min,
    input  logic [5:0]      cal_hour,
    input  logic            cal_pm,
    input  logic [5:0]      cal_date,
    input  logic [2:0]      cal_wday,
    input  logic [SS_W-1:0] cal_subsec,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [1:0]      rd_addr,
    output logic [31:0]     rd_data,
    output logic            alarm_flag,
    output logic            cfg_writable,
    output logic            alarm_irq,
    output logic            alarm_pin
);

    alarm_time_t       time_cfg;
    logic [SS_W-1:0]   ss_val;
    logic [CODE_W-1:0] ss_code;
    logic              alarm_en, irq_en, pin_low, flag_clr, match;

    cal_alarm_regs #(.SS_W(SS_W), .SYNC_TICKS(SYNC_TICKS)) regs_i (
        .clk(clk), .rst_n(rst_n), .cal_tick(cal_tick), .init_mode(init_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .alarm_flag(alarm_flag), .rd_data(rd_data), .time_cfg(time_cfg),
        .ss_val(ss_val), .ss_code(ss_code), .alarm_en(alarm_en), .irq_en(irq_en),
        .pin_low(pin_low), .flag_clr(flag_clr), .cfg_writable(cfg_writable)
    );

    cal_alarm_match #(.SS_W(SS_W)) match_i (
        .time_cfg(time_cfg), .ss_val(ss_val), .ss_code(ss_code), .hour12(hour12),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour), .cal_pm(cal_pm),
        .cal_date(cal_date), .cal_wday(cal_wday), .cal_subsec(cal_subsec),
        .match(match)
    );

    cal_alarm_flag flag_i (
        .clk(clk), .rst_n(rst_n), .cal_tick(cal_tick), .alarm_en(alarm_en),
        .match(match), .flag_clr(flag_clr), .irq_en(irq_en), .pin_low(pin_low),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq), .alarm_pin(alarm_pin)
    );

endmodule

// File: tb/cal_alarm_unit_tb_top.sv
// Self-checking bench: vector table for the comparison, then directed tests.
module cal_alarm_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_tick = 1'b0, init_mode = 1'b0, hour12 = 1'b0;
    logic [6:0]  cal_sec = '0, cal_min = '0;
    logic [5:0]  cal_hour = '0, cal_date = '0;
    logic        cal_pm = 1'b0;
    logic [2:0]  cal_wday = '0;
    logic [14:0] cal_subsec = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        alarm_flag, cfg_writable, alarm_irq, alarm_pin;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cal_alarm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cal_tick(cal_tick), .init_mode(init_mode),
        .hour12(hour12), .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_pm(cal_pm), .cal_date(cal_date), .cal_wday(cal_wday),
        .cal_subsec(cal_subsec), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .alarm_flag(alarm_flag), .cfg_writable(cfg_writable),
        .alarm_irq(alarm_irq), .alarm_pin(alarm_pin)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  msk;     // day, hour, minute, second
        logic        wsel;
        logic        apm;
        logic [25:0] atime;   // day, hour, minute, second
        logic [3:0]  sscode;
        logic [14:0] ssval;
        logic        fmt12;
        logic [25:0] ctime;
        logic        cpm;
        logic [2:0]  cwday;
        logic [14:0] css;
        logic        exp;
    } vec_t;

    localparam logic [25:0] TA = {6'h15, 6'h08, 7'h30, 7'h45};
    localparam logic [25:0] TW = {6'h03, 6'h08, 7'h30, 7'h45};
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 4'b0000, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, TA, 1'b0, 3'd1, 15'h0,    1'b1}, // R1 exact
        '{4'd1, 4'b0000, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h15,6'h08,7'h30,7'h46}, 1'b0, 3'd1, 15'h0, 1'b0}, // R1 sec
        '{4'd2, 4'b0001, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h15,6'h08,7'h30,7'h46}, 1'b0, 3'd1, 15'h0, 1'b1}, // R2 sec mask
        '{4'd1, 4'b0000, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h15,6'h08,7'h31,7'h45}, 1'b0, 3'd1, 15'h0, 1'b0}, // R1 min
        '{4'd2, 4'b0010, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h15,6'h08,7'h31,7'h45}, 1'b0, 3'd1, 15'h0, 1'b1}, // R2 min mask
        '{4'd1, 4'b0000, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h15,6'h09,7'h30,7'h45}, 1'b0, 3'd1, 15'h0, 1'b0}, // R1 hour
        '{4'd1, 4'b0000, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h16,6'h08,7'h30,7'h45}, 1'b0, 3'd1, 15'h0, 1'b0}, // R1 date
        '{4'd2, 4'b1000, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h16,6'h08,7'h30,7'h45}, 1'b0, 3'd1, 15'h0, 1'b1}, // R2 day mask
        '{4'd3, 4'b0000, 1'b1, 1'b0, TW, 4'd0,  15'h0,    1'b0, {6'h20,6'h08,7'h30,7'h45}, 1'b0, 3'd3, 15'h0, 1'b1}, // R3 weekday hit
        '{4'd3, 4'b0000, 1'b1, 1'b0, TW, 4'd0,  15'h0,    1'b0, {6'h03,6'h08,7'h30,7'h45}, 1'b0, 3'd4, 15'h0, 1'b0}, // R3 weekday miss
        '{4'd4, 4'b0000, 1'b0, 1'b1, TA, 4'd0,  15'h0,    1'b1, TA, 1'b0, 3'd1, 15'h0,    1'b0}, // R4 12h pm differs
        '{4'd4, 4'b0100, 1'b0, 1'b1, TA, 4'd0,  15'h0,    1'b1, TA, 1'b0, 3'd1, 15'h0,    1'b1}, // R4 hour masked
        '{4'd4, 4'b0000, 1'b0, 1'b1, TA, 4'd0,  15'h0,    1'b0, TA, 1'b0, 3'd1, 15'h0,    1'b1}, // R4 24h ignores pm
        '{4'd4, 4'b0000, 1'b0, 1'b1, TA, 4'd0,  15'h0,    1'b1, TA, 1'b1, 3'd1, 15'h0,    1'b1}, // R4 12h pm equal
        '{4'd2, 4'b1111, 1'b0, 1'b0, TA, 4'd0,  15'h0,    1'b0, {6'h01,6'h23,7'h59,7'h00}, 1'b1, 3'd7, 15'h1ABC, 1'b1}, // R2 all masked
        '{4'd5, 4'b1111, 1'b0, 1'b0, TA, 4'd4,  15'h0005, 1'b0, TA, 1'b0, 3'd1, 15'h7FF5, 1'b1}, // R5 low 4 equal
        '{4'd5, 4'b1111, 1'b0, 1'b0, TA, 4'd4,  15'h0005, 1'b0, TA, 1'b0, 3'd1, 15'h0006, 1'b0}, // R5 low 4 differ
        '{4'd5, 4'b1111, 1'b0, 1'b0, TA, 4'd15, 15'h1234, 1'b0, TA, 1'b0, 3'd1, 15'h1234, 1'b1}, // R5 full equal
        '{4'd5, 4'b1111, 1'b0, 1'b0, TA, 4'd15, 15'h1234, 1'b0, TA, 1'b0, 3'd1, 15'h5234, 1'b0}, // R5 bit 14 seen
        '{4'd5, 4'b1111, 1'b0, 1'b0, TA, 4'd14, 15'h1234, 1'b0, TA, 1'b0, 3'd1, 15'h5234, 1'b1}  // R5 bit 14 ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        cal_tick = 1'b1;
        @(negedge clk);
        cal_tick = 1'b0;
    endtask

    task automatic set_cal(input logic [25:0] t, input logic pm, input logic [2:0] wd,
                           input logic [14:0] ss);
        cal_date = t[25:20]; cal_hour = t[19:14]; cal_min = t[13:7]; cal_sec = t[6:0];
        cal_pm = pm; cal_wday = wd; cal_subsec = ss;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 flag", {31'b0, alarm_flag}, 32'd0);
        check("R10 irq", {31'b0, alarm_irq}, 32'd0);
        check("R10 pin", {31'b0, alarm_pin}, 32'd0);
        check("R10 writable", {31'b0, cfg_writable}, 32'd1);
        reg_rd(2'd0, rv); check("R10 ctrl read", rv, 32'h20);
        reg_rd(2'd1, rv); check("R10 time read", rv, 32'h0);
        reg_rd(2'd2, rv); check("R10 subsec read", rv, 32'h0);

        // R7: writable status timing
        reg_wr(2'd0, 32'h11);
        check("R7 low while enabled", {31'b0, cfg_writable}, 32'd0);
        reg_wr(2'd0, 32'h10);
        check("R7 low after disable", {31'b0, cfg_writable}, 32'd0);
        tick();
        check("R7 low after one tick", {31'b0, cfg_writable}, 32'd0);
        tick();
        check("R7 high after two ticks", {31'b0, cfg_writable}, 32'd1);

        // Vector table walk (R1 to R5)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            reg_wr(2'd0, 32'h0);
            reg_wr(2'd1, {v.msk, v.wsel, v.apm, v.atime});
            reg_wr(2'd2, {4'h0, v.sscode, 9'h0, v.ssval});
            hour12 = v.fmt12;
            set_cal(v.ctime, v.cpm, v.cwday, v.css);
            reg_wr(2'd0, 32'h1);
            tick();
            checks++;
            if (alarm_flag !== v.exp) begin
                errors++;
                $display("FAIL R%0d vector %0d: got %b expected %b", v.req, i, alarm_flag, v.exp);
            end
        end
        hour12 = 1'b0;

        // R6: protected writes
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd1, {6'b0, TA});
        reg_wr(2'd2, 32'h0300_0007);
        reg_wr(2'd0, 32'h1);
        reg_wr(2'd1, 32'hF000_0000);
        reg_wr(2'd2, 32'h0F00_7FFF);
        reg_rd(2'd1, rv); check("R6 time locked", rv, {6'b0, TA});
        reg_rd(2'd2, rv); check("R6 subsec locked", rv, 32'h0300_0007);
        init_mode = 1'b1;
        reg_wr(2'd1, 32'hF000_0000);
        init_mode = 1'b0;
        reg_rd(2'd1, rv); check("R6 init mode write", rv, 32'hF000_0000);

        // R1/R8: tick gating, sticky flag, no retrigger
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd1, 32'hF000_0000);
        reg_wr(2'd2, 32'h0F00_0000);
        set_cal(TA, 1'b0, 3'd1, 15'h0);
        tick();
        check("R1 disabled no set", {31'b0, alarm_flag}, 32'd0);
        reg_wr(2'd0, 32'h1);
        repeat (4) @(negedge clk);
        check("R1 no set between ticks", {31'b0, alarm_flag}, 32'd0);
        tick();
        check("R1 set on tick", {31'b0, alarm_flag}, 32'd1);
        tick();
        check("R8 sticky", {31'b0, alarm_flag}, 32'd1);
        reg_wr(2'd0, 32'h11);
        check("R8 keep bit preserves", {31'b0, alarm_flag}, 32'd1);
        reg_wr(2'd0, 32'h01);
        check("R8 cleared", {31'b0, alarm_flag}, 32'd0);
        tick();
        check("R8 no retrigger", {31'b0, alarm_flag}, 32'd0);
        cal_subsec = 15'h1;
        tick();
        check("R8 mismatch", {31'b0, alarm_flag}, 32'd0);
        cal_subsec = 15'h0;
        tick();
        check("R8 fresh match", {31'b0, alarm_flag}, 32'd1);

        // R9: interrupt gate and pin polarity
        check("R9 irq gated", {31'b0, alarm_irq}, 32'd0);
        check("R9 pin high", {31'b0, alarm_pin}, 32'd1);
        reg_wr(2'd0, 32'h13);
        check("R9 irq on", {31'b0, alarm_irq}, 32'd1);
        reg_wr(2'd0, 32'h15);
        check("R9 pin inverted set", {31'b0, alarm_pin}, 32'd0);
        reg_wr(2'd0, 32'h05);
        check("R9 pin inverted clear", {31'b0, alarm_pin}, 32'd1);
        reg_rd(2'd0, rv); check("R9 ctrl read", rv, 32'h05);

        done = 1;
        summary();
        $finish;
    end

endmodule